// File: doc/BRIEF.md
# Port-Constrained Three-Wide Issue Selector

This block decides, every clock cycle, which entries of an instruction window are launched into execution. The window holds instructions that are already ready and free of dependencies on one another. Each entry carries a class bit that marks it as a memory access (load or store) or as an ALU operation. The machine launches up to three instructions per cycle. It has three ALUs but a single memory port, so the total launch width and the per-class unit count are enforced together. A lone memory port therefore limits loads even when launch slots are still free.

The window lives outside the block and is presented as per-entry valid and class vectors, with slot 0 the oldest. The block returns a per-entry grant vector in the same cycle. It also returns the leftover window, which holds the entries that stay behind, packed toward slot 0 with their age order kept, so the surrounding logic can write it back. Two free-running counters, one of elapsed cycles and one of granted instructions, let a user measure the achieved instructions per cycle.

Top module: `mem_port_issue_sel`

## Requirements
- R1: No more than ISSUE_W (default 3) grant bits are set in any cycle.
- R2: No more than MEM_PORTS (default 1) granted entries have the class bit set. A class bit of 1 marks a load/store and 0 marks an ALU operation. Two load/store entries are therefore never granted in the same cycle, even when they are independent.
- R3: Up to ALU_UNITS (default 3) ALU entries can be granted in one cycle. A window holding only ALU entries gets its three oldest valid entries granted.
- R4: Grants go out in age order, with slot 0 the oldest. A valid entry is left out only when the older granted entries have already used the full width, or have used every unit of its class. An invalid entry is never granted.
- R5: The leftover window holds every valid entry that was not granted, packed from slot 0 upward in age order and carrying its class bit. All slots above the leftover entries have valid and class both 0.
- R6: A window of two loads followed by three ALU operations drains in two cycles. The first cycle grants slots 0, 2 and 3. The leftover window then holds a load in slot 0 and an ALU op in slot 1, and both are granted in the second cycle.
- R7: While reset is held, both counters read 0. After reset, the cycle counter rises by one on every clock and the issued counter rises by the number of grants made in that cycle. Both counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset for the counters |
| win_valid | input | WIN | Per-slot valid, with slot 0 the oldest |
| win_mem | input | WIN | Per-slot class: 1 for load/store, 0 for ALU |
| issue_grant | output | WIN | Per-slot launch grant for this cycle |
| left_valid | output | WIN | Valid bits of the compacted leftover window |
| left_mem | output | WIN | Class bits of the compacted leftover window |
| cyc_count | output | CNT_W | Cycles elapsed since reset |
| issued_count | output | CNT_W | Instructions granted since reset |

## Verification
On every clock the assertions check the width cap, the memory-port cap, that no invalid entry is granted, and that both counters advance by exactly one cycle and by the number of grants made. Whether a skipped entry was skipped for a legitimate reason (the oldest-first rule), the exact slot-by-slot packing of the leftover window, and the two-cycle drain of the two-load group can only be shown by the bench's scenarios. The bench compares each of these against its own reference model over hand-picked windows and several hundred random ones.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;
    localparam int DEF_WIN       = 8;
    localparam int DEF_ISSUE_W   = 3;
    localparam int DEF_MEM_PORTS = 1;
    localparam int DEF_ALU_UNITS = 3;
    localparam int DEF_CNT_W     = 16;

    typedef enum logic {
        CLS_ALU = 1'b0,
        CLS_MEM = 1'b1
    } op_class_e;
endpackage

// File: rtl/issue_pick.sv
module issue_pick
    import issue_sel_pkg::*;
#(
    parameter int WIN       = DEF_WIN,
    parameter int ISSUE_W   = DEF_ISSUE_W,
    parameter int MEM_PORTS = DEF_MEM_PORTS,
    parameter int ALU_UNITS = DEF_ALU_UNITS,
    localparam int NW       = $clog2(ISSUE_W + 1)
) (
    input  logic [WIN-1:0] valid,
    input  logic [WIN-1:0] mem,
    output logic [WIN-1:0] grant,
    output logic [NW-1:0]  n_grant
);
    // Greedy walk from the oldest slot; each slot sees the tallies of older grants.
    always_comb begin
        int tot;
        int nm;
        int na;
        tot   = 0;
        nm    = 0;
        na    = 0;
        grant = '0;
        for (int i = 0; i < WIN; i++) begin
            if (valid[i] && tot < ISSUE_W) begin
                if (op_class_e'(mem[i]) == CLS_MEM) begin
                    if (nm < MEM_PORTS) begin
                        grant[i] = 1'b1;
                        nm++;
                        tot++;
                    end
                end else if (na < ALU_UNITS) begin
                    grant[i] = 1'b1;
                    na++;
                    tot++;
                end
            end
        end
        n_grant = NW'(tot);
    end
endmodule

// File: rtl/window_compact.sv
module window_compact #(
    parameter int WIN = 8
) (
    input  logic [WIN-1:0] valid,
    input  logic [WIN-1:0] mem,
    input  logic [WIN-1:0] grant,
    output logic [WIN-1:0] out_valid,
    output logic [WIN-1:0] out_mem
);
    logic [WIN-1:0] stay;
    assign stay = valid & ~grant;

    // Each output slot j takes the survivor whose rank among survivors is j.
    for (genvar j = 0; j < WIN; j++) begin : g_slot
        always_comb begin
            int rank;
            rank         = 0;
            out_valid[j] = 1'b0;
            out_mem[j]   = 1'b0;
            for (int i = 0; i < WIN; i++) begin
                if (stay[i]) begin
                    if (rank == j) begin
                        out_valid[j] = 1'b1;
                        out_mem[j]   = mem[i];
                    end
                    rank++;
                end
            end
        end
    end
endmodule

// File: rtl/issue_counters.sv
module issue_counters #(
    parameter int CNT_W = 16,
    parameter int NW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    n_grant,
    output logic [CNT_W-1:0] cycles,
    output logic [CNT_W-1:0] issued
);
    typedef struct packed {
        logic [CNT_W-1:0] cycles;
        logic [CNT_W-1:0] issued;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d        = cnt_q;
        cnt_d.cycles = cnt_q.cycles + CNT_W'(1);
        cnt_d.issued = cnt_q.issued + CNT_W'(n_grant);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cycles = cnt_q.cycles;
    assign issued = cnt_q.issued;

    assert_cycle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q.cycles == CNT_W'($past(cnt_q.cycles) + CNT_W'(1)));
    assert_issued_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q.issued == CNT_W'($past(cnt_q.issued) + CNT_W'($past(n_grant))));
endmodule

// File: rtl/mem_port_issue_sel.sv
module mem_port_issue_sel
    import issue_sel_pkg::*;
#(
    parameter int WIN       = DEF_WIN,
    parameter int ISSUE_W   = DEF_ISSUE_W,
    parameter int MEM_PORTS = DEF_MEM_PORTS,
    parameter int ALU_UNITS = DEF_ALU_UNITS,
    parameter int CNT_W     = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN-1:0]   win_valid,
    input  logic [WIN-1:0]   win_mem,
    output logic [WIN-1:0]   issue_grant,
    output logic [WIN-1:0]   left_valid,
    output logic [WIN-1:0]   left_mem,
    output logic [CNT_W-1:0] cyc_count,
    output logic [CNT_W-1:0] issued_count
);
    localparam int NW = $clog2(ISSUE_W + 1);

    logic [NW-1:0] n_grant;

    issue_pick #(
        .WIN(WIN), .ISSUE_W(ISSUE_W), .MEM_PORTS(MEM_PORTS), .ALU_UNITS(ALU_UNITS)
    ) u_pick (
        .valid(win_valid), .mem(win_mem), .grant(issue_grant), .n_grant(n_grant)
    );

    window_compact #(.WIN(WIN)) u_compact (
        .valid(win_valid), .mem(win_mem), .grant(issue_grant),
        .out_valid(left_valid), .out_mem(left_mem)
    );

    issue_counters #(.CNT_W(CNT_W), .NW(NW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .n_grant(n_grant),
        .cycles(cyc_count), .issued(issued_count)
    );

    assert_width_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_grant) <= ISSUE_W);
    assert_one_mem_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_grant & win_mem) <= MEM_PORTS);
    assert_no_idle_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant & ~win_valid) == '0);
    assert_left_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(left_valid) + $countones(issue_grant) == $countones(win_valid));
endmodule

// File: tb/mem_port_issue_sel_bench.sv
module mem_port_issue_sel_bench;
    localparam int WIN   = 8;
    localparam int CNT_W = 16;

    typedef struct {
        logic [WIN-1:0] g;
        logic [WIN-1:0] lv;
        logic [WIN-1:0] lm;
        string          tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WIN-1:0] win_valid = '0, win_mem = '0;
    logic [WIN-1:0] issue_grant, left_valid, left_mem;
    logic [CNT_W-1:0] cyc_count, issued_count;

    int errors = 0, checks = 0;
    int ncyc = 0, niss = 0, cur_n = 0;
    exp_t q[$];
    event ev_drv;
    bit done = 0;

    always #5 clk = ~clk;

    mem_port_issue_sel u_mem_port_issue_sel (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_mem(win_mem),
        .issue_grant(issue_grant), .left_valid(left_valid), .left_mem(left_mem),
        .cyc_count(cyc_count), .issued_count(issued_count)
    );

    // Reference: oldest first, 3 total, 1 load/store, 3 ALU.
    function automatic exp_t model(logic [WIN-1:0] v, logic [WIN-1:0] m);
        exp_t e;
        int used = 0, mu = 0, k = 0;
        e.g = '0; e.lv = '0; e.lm = '0;
        for (int i = 0; i < WIN; i++)
            if (v[i] && used < 3 && (m[i] ? mu < 1 : 1)) begin
                e.g[i] = 1'b1; used++; if (m[i]) mu++;
            end
        for (int i = 0; i < WIN; i++)
            if (v[i] && !e.g[i]) begin e.lv[k] = 1'b1; e.lm[k] = m[i]; k++; end
        return e;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [WIN-1:0] v, logic [WIN-1:0] m, string tag);
        exp_t e;
        @(negedge clk);
        win_valid = v;
        win_mem   = m;
        e = model(v, m);
        e.tag = tag;
        cur_n = $countones(e.g);
        q.push_back(e);
        ->ev_drv;
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            @(ev_drv);
            #1;
            e = q.pop_front();
            chk(issue_grant == e.g, {e.tag, " grant"}, 32'(issue_grant), 32'(e.g));
            chk(left_valid == e.lv, {e.tag, " R5 left_valid"}, 32'(left_valid), 32'(e.lv));
            chk(left_mem == e.lm, {e.tag, " R5 left_mem"}, 32'(left_mem), 32'(e.lm));
        end
    end

    always @(posedge clk) if (rst_n) begin ncyc++; niss += cur_n; end

    initial begin : watchdog
        #2ms;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        #2;
        chk(cyc_count == 0 && issued_count == 0, "R7 reset counters",
            32'({cyc_count, issued_count}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: loads in slots 0,1; ALU in 2..4
        drive(8'b0001_1111, 8'b0000_0011, "R6 first");
        #2;
        chk(issue_grant == 8'b0000_1101, "R6 cycle1 grant", 32'(issue_grant), 32'h0d);
        chk(left_valid == 8'b0000_0011 && left_mem == 8'b0000_0001, "R6 leftover",
            32'({left_valid, left_mem}), 32'h0301);
        drive(left_valid, left_mem, "R6 second");
        #2;
        chk(issue_grant == 8'b0000_0011, "R6 cycle2 grant", 32'(issue_grant), 32'h03);

        drive(8'hFF, 8'h00, "R3 all ALU");
        #2;
        chk(issue_grant == 8'b0000_0111, "R3 three ALUs", 32'(issue_grant), 32'h07);
        drive(8'hFF, 8'hFF, "R2 all loads");
        #2;
        chk(issue_grant == 8'b0000_0001, "R2 single port", 32'(issue_grant), 32'h01);
        drive(8'b0000_0011, 8'b0000_0011, "R2 two independent loads");
        drive(8'b0011_1111, 8'b0000_0110, "R4 skip second load");
        #2;
        chk(issue_grant == 8'b0000_1011, "R4 skip mem slot2", 32'(issue_grant), 32'h0b);
        drive(8'b0000_1111, 8'b0000_1000, "R1 width full");
        #2;
        chk(issue_grant == 8'b0000_0111, "R1 load blocked by width", 32'(issue_grant), 32'h07);
        drive(8'b0110_0000, 8'b0000_0000, "R4 gaps");
        #2;
        chk(issue_grant == 8'b0110_0000 && left_valid == 0, "R4 R5 gapped window",
            32'({issue_grant, left_valid}), 32'h6000);
        drive(8'h00, 8'hFF, "R4 empty");

        for (int n = 0; n < 400; n++)
            drive(WIN'($urandom), WIN'($urandom), "R1 R2 R4 random");

        drive(8'h00, 8'h00, "idle");
        @(negedge clk);
        #2;
        chk(cyc_count == CNT_W'(ncyc), "R7 cycle count", 32'(cyc_count), 32'(CNT_W'(ncyc)));
        chk(issued_count == CNT_W'(niss), "R7 issued count", 32'(issued_count), 32'(CNT_W'(niss)));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule